// File: doc/BRIEF.md
# Cycle-Order Frequency Comparator

This block sorts a test clock into one of three bands (above a high reference, between the two references, below a low reference) without counting cycles. Each of the three lines gets its own period detector, which reports completion once it has seen two falling edges. The comparator decides by which line completes a period first. A line that finishes its period sooner has a shorter period and so a higher frequency.

All three lines are asynchronous to the system clock. Each line passes through a synchronizer and an edge detector before it reaches its period detector. The three completion flags and a verdict flag form a 4-bit next state. The system clock loads that next state into a current-state register. The outputs are decoded from the step between the current state and the next state, not from either state alone.

The test line completing is the event that produces a verdict. The verdict is one pulse, one clock long, on exactly one of three outputs. After that the block stays quiet until it is cleared. A surrounding controller is expected to supply the timeout and issue the clear.

Top module: `freq_order_cmp`

## Requirements
- R1: While `rst_ni` is low, and in the first cycles after it rises, `fast_o`, `slow_o` and `ok_o` are all low.
- R2: A period on a line completes only on the second falling edge seen on that line since the last reset or clear. A single falling edge produces no output.
- R3: When the test line completes while neither reference has completed, `fast_o` pulses.
- R4: When the test line completes after the high reference has completed and before the low reference has completed, `ok_o` pulses.
- R5: When the test line completes after the low reference has completed, `slow_o` pulses. This holds whether or not the high reference completed before it.
- R6: When the test line and a reference complete in the same clock cycle, that reference counts as already complete. A tie with the high reference gives `ok_o`; a tie with the low reference gives `slow_o`.
- R7: A verdict pulse is high for exactly one clock cycle.
  - Timing: if the second falling edge of the test line is set up before clock edge k, the pulse is high from clock edge k+3 until clock edge k+4.
  - Exclusivity: at most one of the three outputs is high at any time.
- R8: After a verdict, further edges on any line produce no output until `clr_i` is applied.
- R9: `clr_i`, sampled high on a clock edge, returns the state to 0. It also clears every detector, including a partly seen period, and clears any pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of state and detectors |
| ref_lo_i | input | 1 | Low-frequency reference, asynchronous |
| ref_hi_i | input | 1 | High-frequency reference, asynchronous |
| test_i | input | 1 | Clock under test, asynchronous |
| fast_o | output | 1 | One-cycle pulse: test is faster than the high reference |
| slow_o | output | 1 | One-cycle pulse: test is slower than the low reference |
| ok_o | output | 1 | One-cycle pulse: test lies between the two references |

## Verification
The timing chain for a verdict is fixed. A falling edge driven before clock edge k passes two synchronizer stages and is flagged by the edge detector. The detector's completion flag is set at edge k+2, and the registered verdict pulse appears at edge k+3. The bench therefore notes the cycle in which it drives the test line's second falling edge. It queues the expected verdict together with that cycle plus four. The monitor samples on the falling clock edge and compares both the pulse kind and the cycle in which it appears. Any pulse that the queue does not expect is counted as a failure, and this is how the single-edge, post-verdict and clear cases are observed.

// File: rtl/freq_cmp_pkg.sv
package freq_cmp_pkg;
  localparam int unsigned N_LINES = 3;
  localparam int unsigned ST_W    = N_LINES + 1;
  // state bit positions; decoder depends on them
  localparam int unsigned B_TEST = 0;
  localparam int unsigned B_HI   = 1;
  localparam int unsigned B_LO   = 2;
  localparam int unsigned B_DONE = 3;

  typedef enum logic [1:0] {
    V_NONE = 2'd0,
    V_FAST = 2'd1,
    V_OK   = 2'd2,
    V_SLOW = 2'd3
  } verdict_e;
endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          FALL_EDGE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  localparam logic IDLE = FALL_EDGE;

  logic [STAGES:0] pipe_q;
  logic            sync_w, prev_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES+1){IDLE}};
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign sync_w = pipe_q[STAGES-1];
  assign prev_w = pipe_q[STAGES];

  generate
    if (FALL_EDGE) begin : g_fall
      assign edge_o = prev_w & ~sync_w;
    end else begin : g_rise
      assign edge_o = ~prev_w & sync_w;
    end
  endgenerate
endmodule

// File: rtl/fc_period_det.sv
module fc_period_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic edge_i,
  output logic done_o
);
  logic armed_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (en_i && edge_i && !done_q) begin
      if (armed_q) done_q  <= 1'b1;
      else         armed_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  assert_done_after_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(armed_q));
  assert_clear_det_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_q && !armed_q));
endmodule

// File: rtl/fc_order_fsm.sv
module fc_order_fsm
  import freq_cmp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [N_LINES-1:0]  done_i,
  output logic                halt_o,
  output logic                fast_o,
  output logic                slow_o,
  output logic                ok_o
);
  logic [ST_W-1:0] cur_q, nxt_w;
  logic            fire_w;
  verdict_e        kind_w;
  logic            fast_q, slow_q, ok_q;

  // verdict event: test line completes for the first time
  assign fire_w = done_i[B_TEST] & ~cur_q[B_TEST] & ~cur_q[B_DONE];
  assign nxt_w  = {cur_q[B_DONE] | fire_w, done_i};

  // refs completing in the same cycle count as already complete
  always_comb begin
    if (done_i[B_LO])      kind_w = V_SLOW;
    else if (done_i[B_HI]) kind_w = V_OK;
    else                   kind_w = V_FAST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      ok_q   <= 1'b0;
    end else if (clr_i) begin
      cur_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      cur_q  <= nxt_w;
      fast_q <= fire_w && (kind_w == V_FAST);
      slow_q <= fire_w && (kind_w == V_SLOW);
      ok_q   <= fire_w && (kind_w == V_OK);
    end
  end

  assign halt_o = cur_q[B_DONE];
  assign fast_o = fast_q;
  assign slow_o = slow_q;
  assign ok_o   = ok_q;

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fast_q, slow_q, ok_q}));
  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_q || slow_q || ok_q) |=> !(fast_q || slow_q || ok_q));
  assert_quiet_after_verdict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q[B_DONE] && !clr_i) |=> !(fast_q || slow_q || ok_q));
  assert_clear_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cur_q == '0 && !fast_q && !slow_q && !ok_q));
  assert_slow_needs_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_q |-> $past(done_i[B_LO]));
  assert_fast_no_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_q |-> ($past(!done_i[B_HI]) && $past(!done_i[B_LO])));
endmodule

// File: rtl/freq_order_cmp.sv
module freq_order_cmp
  import freq_cmp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          FALL_EDGE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_lo_i,
  input  logic ref_hi_i,
  input  logic test_i,
  output logic fast_o,
  output logic slow_o,
  output logic ok_o
);
  logic [N_LINES-1:0] line_w, edge_w, done_w;
  logic               halt_w;

  assign line_w[B_TEST] = test_i;
  assign line_w[B_HI]   = ref_hi_i;
  assign line_w[B_LO]   = ref_lo_i;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    fc_edge_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(FALL_EDGE)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_w[i]),
      .edge_o(edge_w[i])
    );
    fc_period_det u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr_i),
      .en_i  (~halt_w),
      .edge_i(edge_w[i]),
      .done_o(done_w[i])
    );
  end

  fc_order_fsm u_fsm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .done_i(done_w),
    .halt_o(halt_w),
    .fast_o(fast_o),
    .slow_o(slow_o),
    .ok_o  (ok_o)
  );
endmodule

// File: tb/freq_order_cmp_tb_top.sv
module freq_order_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K_FAST = 1, K_OK = 2, K_SLOW = 3;
  localparam logic [2:0] M_T = 3'b001, M_H = 3'b010, M_L = 3'b100;

  logic clk_i = 1'b0, rst_ni = 1'b0, clr_i = 1'b0;
  logic [2:0] ln = 3'b111;
  logic fast_o, slow_o, ok_o;
  int cyc = 0, checks = 0, errors = 0, seen = 0, expected = 0;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t exp_q[$];
  int cnt [3];
  bit verdict;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  freq_order_cmp dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .ref_lo_i(ln[2]), .ref_hi_i(ln[1]), .test_i(ln[0]),
    .fast_o(fast_o), .slow_o(slow_o), .ok_o(ok_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one falling edge on every masked line; model updates in the same order
  task automatic edge_on(input logic [2:0] mask, input string req);
    int c;
    @(negedge clk_i);
    ln = ln & ~mask;
    c = cyc;
    if (!verdict) begin
      for (int i = 0; i < 3; i++) if (mask[i] && cnt[i] < 2) cnt[i]++;
      if (cnt[0] == 2) begin
        exp_t e;
        e.kind = (cnt[2] == 2) ? K_SLOW : (cnt[1] == 2) ? K_OK : K_FAST;
        e.at   = c + 4;
        e.req  = req;
        exp_q.push_back(e);
        expected++;
        verdict = 1'b1;
      end
    end
    repeat (2) @(negedge clk_i);
    ln = ln | mask;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic period(input logic [2:0] mask, input string req);
    edge_on(mask, req);
    edge_on(mask, req);
  endtask

  task automatic clear();
    repeat (6) @(negedge clk_i);
    chk(seen == expected, "R8 pulse count before clear", seen, expected);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    chk({fast_o, slow_o, ok_o} == 3'b000, "R9 outputs after clear", {fast_o, slow_o, ok_o}, 0);
    for (int i = 0; i < 3; i++) cnt[i] = 0;
    verdict = 1'b0;
  endtask

  // monitor: every pulse must match the head of the queue in kind and cycle
  always @(negedge clk_i) begin
    if (rst_ni && (fast_o || slow_o || ok_o)) begin
      int k;
      seen++;
      k = fast_o ? K_FAST : ok_o ? K_OK : K_SLOW;
      chk(32'(fast_o) + 32'(slow_o) + 32'(ok_o) == 1, "R7 exclusive",
          32'(fast_o) + 32'(slow_o) + 32'(ok_o), 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8/R2 unexpected pulse", k, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(k == e.kind, {e.req, " kind"}, k, e.kind);
        chk(cyc == e.at, "R7 pulse cycle", cyc, e.at);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) cnt[i] = 0;
    verdict = 1'b0;
    repeat (3) @(negedge clk_i);
    chk({fast_o, slow_o, ok_o} == 3'b000, "R1 outputs in reset", {fast_o, slow_o, ok_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({fast_o, slow_o, ok_o} == 3'b000, "R1 outputs after reset", {fast_o, slow_o, ok_o}, 0);

    // R2: a single edge on every line is not a period
    edge_on(M_T | M_H | M_L, "R2");
    clear();

    // R3: test alone
    period(M_T, "R3 fast");
    // R8: activity after verdict ignored
    period(M_H, "R8");
    period(M_L, "R8");
    period(M_T, "R8");
    clear();

    // R3 with one reference half way
    edge_on(M_H, "R3");
    period(M_T, "R3 fast partial ref");
    clear();

    // R4: high then test
    period(M_H, "R4");
    period(M_T, "R4 ok");
    clear();

    // R5: high, low, test
    period(M_H, "R5");
    period(M_L, "R5");
    period(M_T, "R5 slow");
    clear();

    // R5: low alone first
    period(M_L, "R5");
    period(M_T, "R5 slow low first");
    clear();

    // R6: ties
    period(M_T | M_H, "R6 tie high");
    clear();
    period(M_T | M_L, "R6 tie low");
    clear();
    period(M_T | M_H | M_L, "R6 tie all");
    clear();

    // R9: clear discards a half-seen period
    edge_on(M_T, "R9");
    clear();
    edge_on(M_T, "R9");
    repeat (6) @(negedge clk_i);
    chk(seen == expected, "R9 no verdict after cleared arm", seen, expected);
    edge_on(M_T, "R9 fast after clear");
    repeat (8) @(negedge clk_i);

    chk(exp_q.size() == 0, "R7 missing pulse", exp_q.size(), 0);
    chk(seen == expected, "R8 total pulses", seen, expected);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule